// File: doc/BRIEF.md
# Immediate-to-Memory Byte Store Sequencer

This block is a multi-cycle control unit that carries out a single instruction: store an immediate byte to memory. The destination address is formed from a segment register, a base register and a signed 8-bit displacement. After a start request, the sequencer reads four instruction bytes in a row from consecutive addresses. These are two opcode bytes, then a displacement, then an immediate value. It checks the opcode pair as the bytes arrive, forms the physical address, issues one memory write and signals completion. The memory behind the bus answers reads in the same cycle, with no wait states.

The segment and base registers are preloaded from outside while the sequencer is idle. The starting program counter is captured at the start request. If the opcode pair is not the supported one, the sequencer drops the instruction, raises an error for one cycle and does not write.

States: `ST_IDLE` waits for `start`. `ST_OP1` reads the first opcode byte and moves to `ST_OP2` on a match or to `ST_BAD` otherwise. `ST_OP2` reads the second opcode byte and moves to `ST_DISP` on a match or to `ST_BAD` otherwise. `ST_DISP` reads the displacement and moves to `ST_IMM`. `ST_IMM` reads the immediate byte and moves to `ST_WRITE`. `ST_WRITE` drives the computed address and the data and moves to `ST_DONE`. `ST_DONE` pulses `done` and returns to `ST_IDLE`. `ST_BAD` pulses `err` and returns to `ST_IDLE`.

Top module: `bms_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer returns to idle. After that edge, `rd`, `wr`, `data_oe`, `done` and `err` are all 0.
- R2: When `start` is high at an edge while the sequencer is idle, `pc_start` becomes the program counter. The first read (`rd`=1, `addr`=`pc_start`) occurs in the following cycle.
- R3: A legal instruction produces exactly four read cycles back to back. Their addresses are `pc_start`, `pc_start`+1, `pc_start`+2 and `pc_start`+3, taken modulo 2^20.
- R4: If the first byte read is not C6h, the next cycle has `err`=1. No further reads follow, and there is no write and no `done`.
- R5: If the first byte is C6h and the second byte is not 47h, the next cycle has `err`=1. Exactly two reads occur in total, and there is no write and no `done`.
- R6: The single write occurs in the cycle right after the fourth read. Its `addr` equals (segment×16 + base + sign-extended third byte) mod 2^20.
- R7: During the write, `data_out` equals the fourth byte read. `data_oe` is high exactly in the write cycle, and `rd` and `wr` are never high together.
- R8: `done` is high for exactly one cycle, the cycle right after the write. In that cycle `pc_out` equals `pc_start`+4 mod 2^20.
- R9: When `ld_regs` is high at an edge while idle, the segment register loads `seg_in` and the base register loads `base_in`. While an instruction is in progress, `ld_regs` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an instruction (accepted while idle) |
| pc_start | input | 20 | Address of the first instruction byte |
| ld_regs | input | 1 | Load segment and base registers (accepted while idle) |
| seg_in | input | 16 | Segment register load value |
| base_in | input | 16 | Base register load value |
| data_in | input | 8 | Read data, valid in the same cycle as `rd` |
| addr | output | 20 | Address bus |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| data_out | output | 8 | Write data |
| data_oe | output | 1 | Write data drive enable |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-opcode pulse |
| pc_out | output | 20 | Current program counter |

## Verification
The bench builds the block with its default widths: a 20-bit address, 8-bit data, 16-bit segment and base registers, and a segment shift of 4. At these widths, every one of the 256 displacement values can be swept against segment and base pairs chosen to exercise negative displacements, address wrap past 2^20 and program-counter wrap. Separate sweeps apply all 255 wrong first bytes and all 255 wrong second bytes. The illegal path and the position of the abort are therefore covered completely, not by sampling.

// File: rtl/bms_pkg.sv
package bms_pkg;

    localparam logic [7:0] OPC_FIRST  = 8'hC6;
    localparam logic [7:0] OPC_SECOND = 8'h47;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP1,
        ST_OP2,
        ST_DISP,
        ST_IMM,
        ST_WRITE,
        ST_DONE,
        ST_BAD
    } seq_state_t;

endpackage

// File: rtl/bms_decode.sv
module bms_decode #(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  OPC_A  = 8'hC6,
    parameter logic [7:0]  OPC_B  = 8'h47
) (
    input  logic [DATA_W-1:0] byte_in,
    output logic              first_ok,
    output logic              second_ok
);
    assign first_ok  = (byte_in == DATA_W'(OPC_A));
    assign second_ok = (byte_in == DATA_W'(OPC_B));
endmodule

// File: rtl/bms_ea.sv
module bms_ea #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int REG_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic [REG_W-1:0]  seg,
    input  logic [REG_W-1:0]  base,
    input  logic [DATA_W-1:0] disp,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] seg_term;
    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] disp_term;

    assign seg_term  = ADDR_W'({seg, {SEG_SHIFT{1'b0}}});
    assign base_term = ADDR_W'(base);
    assign disp_term = ADDR_W'($signed(disp));
    assign ea        = seg_term + base_term + disp_term;
endmodule

// File: rtl/bms_seq.sv
module bms_seq
    import bms_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int REG_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc_start,
    input  logic              ld_regs,
    input  logic [REG_W-1:0]  seg_in,
    input  logic [REG_W-1:0]  base_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr,
    output logic              rd,
    output logic              wr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] pc_out
);
    seq_state_t state_q, state_d;

    logic [ADDR_W-1:0] pc_q;
    logic [REG_W-1:0]  seg_q, base_q;
    logic [DATA_W-1:0] tmp_a_q, tmp_b_q;
    logic [ADDR_W-1:0] ea;
    logic              first_ok, second_ok;
    logic              fetching;

    bms_decode #(
        .DATA_W (DATA_W),
        .OPC_A  (OPC_FIRST),
        .OPC_B  (OPC_SECOND)
    ) u_decode (
        .byte_in   (data_in),
        .first_ok  (first_ok),
        .second_ok (second_ok)
    );

    bms_ea #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .REG_W     (REG_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) u_ea (
        .seg  (seg_q),
        .base (base_q),
        .disp (tmp_a_q),
        .ea   (ea)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_OP1;
            ST_OP1:   state_d = first_ok  ? ST_OP2  : ST_BAD;
            ST_OP2:   state_d = second_ok ? ST_DISP : ST_BAD;
            ST_DISP:  state_d = ST_IMM;
            ST_IMM:   state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_BAD:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign fetching = (state_q == ST_OP1) || (state_q == ST_OP2) ||
                      (state_q == ST_DISP) || (state_q == ST_IMM);

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            seg_q   <= '0;
            base_q  <= '0;
            tmp_a_q <= '0;
            tmp_b_q <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                if (start) pc_q <= pc_start;
                if (ld_regs) begin
                    seg_q  <= seg_in;
                    base_q <= base_in;
                end
            end
            if (fetching)            pc_q    <= pc_q + 1'b1;
            if (state_q == ST_DISP)  tmp_a_q <= data_in;
            if (state_q == ST_IMM)   tmp_b_q <= data_in;
        end
    end

    // outputs
    always_comb begin
        addr     = pc_q;
        rd       = 1'b0;
        wr       = 1'b0;
        data_out = '0;
        data_oe  = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_OP1, ST_OP2, ST_DISP, ST_IMM: rd = 1'b1;
            ST_WRITE: begin
                addr     = ea;
                wr       = 1'b1;
                data_out = tmp_b_q;
                data_oe  = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            ST_BAD:   err  = 1'b1;
            default:  ;
        endcase
    end

    assign pc_out = pc_q;

    assert_rdwr_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(rd && wr));

    assert_fetch_step_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && $past(rd) && !$past(rst)) |-> (addr == $past(addr) + 1'b1));

    assert_err_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(rd) && !$past(rst)));

    assert_wr_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        wr |-> ($past(rd) && !$past(rst)));

    assert_done_after_wr_R8: assert property (@(posedge clk) disable iff (rst)
        wr |=> (done && !wr));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_oe_tracks_wr_R7: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (wr && !rd));

endmodule

// File: tb/sim_bms_seq.sv
module sim_bms_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [19:0] pc_start;
    logic        ld_regs;
    logic [15:0] seg_in, base_in;
    logic [7:0]  data_in;
    logic [19:0] addr;
    logic        rd, wr, data_oe, done, err;
    logic [7:0]  data_out;
    logic [19:0] pc_out;

    int total = 0;
    int fails = 0;

    logic [19:0] pc0;
    logic [7:0]  b0, b1, b2, b3;

    always #4 clk = ~clk;

    bms_seq u0 (
        .clk(clk), .rst(rst), .start(start), .pc_start(pc_start),
        .ld_regs(ld_regs), .seg_in(seg_in), .base_in(base_in),
        .data_in(data_in), .addr(addr), .rd(rd), .wr(wr),
        .data_out(data_out), .data_oe(data_oe), .done(done),
        .err(err), .pc_out(pc_out)
    );

    // zero-wait memory holding one instruction
    always_comb begin
        if      (addr == pc0)          data_in = b0;
        else if (addr == pc0 + 20'd1)  data_in = b1;
        else if (addr == pc0 + 20'd2)  data_in = b2;
        else if (addr == pc0 + 20'd3)  data_in = b3;
        else                           data_in = 8'h00;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_ea(input logic [15:0] s, input logic [15:0] b,
                                           input logic [7:0] d);
        int v;
        v = int'(s) * 16 + int'(b) + int'($signed(d));
        return 20'(v & 32'h000F_FFFF);
    endfunction

    task automatic preload(input logic [15:0] s, input logic [15:0] b);
        @(negedge clk);
        ld_regs = 1'b1; seg_in = s; base_in = b;
        @(negedge clk);
        ld_regs = 1'b0;
    endtask

    // kind: 0 legal, 1 bad first byte, 2 bad second byte
    task automatic run(input logic [19:0] p, input logic [15:0] s, input logic [15:0] b,
                       input logic [7:0] x0, input logic [7:0] x1, input logic [7:0] x2,
                       input logic [7:0] x3, input int kind, input bit mid_load);
        int nrd, nwr, ndone, nerr, wcyc, dcyc;
        bit seq_bad, oe_bad;
        logic [19:0] waddr, pcd;
        logic [7:0]  wdata;
        nrd = 0; nwr = 0; ndone = 0; nerr = 0; wcyc = -1; dcyc = -1;
        seq_bad = 0; oe_bad = 0; waddr = '0; pcd = '0; wdata = '0;
        pc0 = p; b0 = x0; b1 = x1; b2 = x2; b3 = x3;
        @(negedge clk);
        start = 1'b1; pc_start = p;
        @(negedge clk);
        start = 1'b0; pc_start = ~p;
        for (int c = 0; c < 8; c++) begin
            if (c > 0) @(negedge clk);
            if (rd) begin
                if (addr !== p + 20'(nrd)) seq_bad = 1;
                nrd++;
            end
            if (wr) begin nwr++; waddr = addr; wdata = data_out; wcyc = c; end
            if ((data_oe !== wr) || (rd && wr)) oe_bad = 1;
            if (done) begin ndone++; pcd = pc_out; dcyc = c; end
            if (err) nerr++;
            if (mid_load && c == 1) begin
                ld_regs = 1'b1; seg_in = ~s; base_in = b ^ 16'h5A5A;
            end else begin
                ld_regs = 1'b0;
            end
        end
        check(!oe_bad, "R7 strobe/oe exclusivity", 32'(oe_bad), 0);
        if (kind == 0) begin
            check(!seq_bad, "R2/R3 read addresses", 32'(seq_bad), 0);
            check(nrd == 4, "R3 read count", 32'(nrd), 4);
            check(nwr == 1 && wcyc == 4, "R6 write cycle", 32'(wcyc), 4);
            check(waddr == exp_ea(s, b, x2), mid_load ? "R9 ld ignored while busy" : "R6 write address",
                  32'(waddr), 32'(exp_ea(s, b, x2)));
            check(wdata == x3, "R7 write data", 32'(wdata), 32'(x3));
            check(ndone == 1 && dcyc == 5, "R8 done pulse", 32'(dcyc), 5);
            check(pcd == p + 20'd4, "R8 pc after done", 32'(pcd), 32'(p + 20'd4));
            check(nerr == 0, "R4 no err on legal", 32'(nerr), 0);
        end else begin
            check(!seq_bad, "R4/R5 read addresses", 32'(seq_bad), 0);
            check(nrd == kind, kind == 1 ? "R4 reads before abort" : "R5 reads before abort",
                  32'(nrd), 32'(kind));
            check(nerr == 1 && nwr == 0 && ndone == 0,
                  kind == 1 ? "R4 err without write" : "R5 err without write",
                  32'(nerr * 256 + nwr * 16 + ndone), 32'h100);
        end
    endtask

    initial begin
        #(8 * 200000);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] segs  [4];
        logic [15:0] bases [4];
        segs  = '{16'h0300, 16'h0000, 16'hFFFF, 16'h1234};
        bases = '{16'h0000, 16'h0080, 16'hFFFF, 16'h0001};
        rst = 1'b1; start = 1'b0; pc_start = '0; ld_regs = 1'b0;
        seg_in = '0; base_in = '0; pc0 = 20'h01000;
        b0 = 8'h00; b1 = 8'h00; b2 = 8'h00; b3 = 8'h00;
        repeat (3) @(negedge clk);
        check(!rd && !wr && !data_oe && !done && !err, "R1 reset outputs",
              {27'b0, rd, wr, data_oe, done, err}, 0);
        rst = 1'b0;

        // worked example
        preload(16'h0300, 16'h0000);
        run(20'h01000, 16'h0300, 16'h0000, 8'hC6, 8'h47, 8'h10, 8'h45, 0, 0);

        // displacement sweep over register pairs
        for (int k = 0; k < 4; k++) begin
            preload(segs[k], bases[k]);
            for (int d = 0; d < 256; d++) begin
                logic [19:0] p;
                p = (k == 2 && d > 250) ? 20'hFFFFE : 20'h01000 + 20'(d * 7 + k);
                run(p, segs[k], bases[k], 8'hC6, 8'h47, 8'(d), 8'(d) ^ 8'hA5, 0, 0);
            end
        end

        // load request while busy must be ignored
        preload(16'h2000, 16'h0100);
        run(20'h00400, 16'h2000, 16'h0100, 8'hC6, 8'h47, 8'hF0, 8'h3C, 0, 1);
        run(20'h00500, 16'h2000, 16'h0100, 8'hC6, 8'h47, 8'h7F, 8'h81, 0, 0);

        // every wrong first byte
        for (int v = 0; v < 256; v++) begin
            if (v != 8'hC6)
                run(20'h02000, 16'h2000, 16'h0100, 8'(v), 8'h47, 8'h10, 8'h45, 1, 0);
        end

        // every wrong second byte
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h47)
                run(20'h03000, 16'h2000, 16'h0100, 8'hC6, 8'(v), 8'h10, 8'h45, 2, 0);
        end

        // reset in the middle of an instruction
        pc0 = 20'h04000; b0 = 8'hC6; b1 = 8'h47;
        @(negedge clk); start = 1'b1; pc_start = 20'h04000;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check(!rd && !wr && !data_oe && !done && !err, "R1 reset mid-run",
              {27'b0, rd, wr, data_oe, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rd && !wr, "R1 idle after reset", {30'b0, rd, wr}, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule